// File: doc/BRIEF.md
# Multi-Chain Scan Load Controller

This controller sits between a serial test-data decompressor and a core with several parallel scan chains of equal length. The decompressor presents one bit at a time with a valid qualifier. The controller collects one bit per chain in a staging register. When the register holds one bit for every chain, it raises a scan-shift enable for one cycle. During that cycle the staged word is driven onto the chain inputs, and every chain takes one bit in parallel.

After one such transfer for every cell position of the chains, the controller pulses a functional-clock enable for one cycle so the core captures the loaded pattern. It then clears its counters and starts on the next pattern straight away. While a transfer or a capture is under way it raises `busy` towards the decompressor. A valid bit offered during that time is dropped and latches a sticky error flag. A wrapping count of applied patterns lets a test environment line up its observations with reference patterns.

The serial stream must be interleaved by cell position. It carries one bit for chain 0, one for chain 1, and so on up to the last chain, then the next cell of every chain in the same order, for every pattern.

Top module: `scan_load_ctrl`

## Requirements
- R1: After reset, `busy`, `scan_en`, `func_en` and `err` are 0 and `pat_cnt` is 0.
- R2: A bit on `din` is taken into staging only on a cycle where `din_vld` is 1 and `busy` is 0. Cycles with `din_vld` at 0 leave staging untouched whatever `din` carries, and `busy` stays 0 while a group is being collected.
- R3: On the cycle after the CHAINS-th accepted bit of a group, `scan_en` is 1 for exactly one cycle, and `func_en` is 0 during that cycle.
- R4: During a `scan_en` cycle, bit c of `chain_in` is the (c+1)-th accepted bit of that group: the first bit goes to chain 0. Across a pattern, chain c therefore receives stream bits c, c+CHAINS, c+2·CHAINS and so on, in that order.
- R5: On the cycle after the CHAIN_LEN-th `scan_en` cycle of a pattern, `func_en` is 1 for exactly one cycle. `func_en` is never 1 at any other time.
- R6: `busy` is 1 exactly on the cycles where `scan_en` or `func_en` is 1.
- R7: `din_vld` at 1 while `busy` is 1 sets `err` on the next cycle. `err` stays set until reset, and the offered bit changes neither staging nor the chain data.
- R8: `pat_cnt` rises by one on the cycle after each `func_en` pulse, wrapping modulo 2^PAT_W.
- R9: On the cycle after a `func_en` pulse, `busy` is 0 and both counters are clear. The next accepted bit is the first bit of chain 0 at the first cell position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 1 | Serial decompressed test data |
| din_vld | input | 1 | Qualifies `din` |
| busy | output | 1 | Transfer or capture in progress; do not offer data |
| scan_en | output | 1 | Scan-clock enable for one parallel shift |
| func_en | output | 1 | Functional-clock enable, one-cycle capture pulse |
| chain_in | output | CHAINS | Parallel scan-chain inputs, bit c feeds chain c |
| pat_cnt | output | PAT_W | Number of patterns applied, wrapping |
| err | output | 1 | Sticky flag: valid data offered while busy |

## Verification
The bench builds the block with four chains of three cells and a 3-bit pattern count. With these values a full pattern is only twelve bits, so many patterns fit in a short run. Each chain holds more than one cell, which exposes both the order across chains and the order within a chain. The pattern count wraps after eight patterns, and the bench runs nine. The short groups make it cheap to place idle gaps with toggling data between accepted bits, to run patterns back to back, and to offer a bit in the middle of a transfer.

// File: rtl/scan_load_ctrl.sv
module scan_load_ctrl #(
  parameter int CHAINS    = 8,
  parameter int CHAIN_LEN = 64,
  parameter int PAT_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              din,
  input  logic              din_vld,
  output logic              busy,
  output logic              scan_en,
  output logic              func_en,
  output logic [CHAINS-1:0] chain_in,
  output logic [PAT_W-1:0]  pat_cnt,
  output logic              err
);
  localparam int BW = (CHAINS > 1) ? $clog2(CHAINS) : 1;
  localparam int LW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [BW-1:0] BIT_LAST = BW'(CHAINS - 1);
  localparam logic [LW-1:0] POS_LAST = LW'(CHAIN_LEN - 1);

  typedef enum logic [1:0] {COLLECT, XFER, APPLY} phase_t;

  phase_t            phase;
  logic [CHAINS-1:0] stage;
  logic [BW-1:0]     bit_cnt;
  logic [LW-1:0]     pos_cnt;
  logic              take;

  assign busy     = (phase != COLLECT);
  assign scan_en  = (phase == XFER);
  assign func_en  = (phase == APPLY);
  assign chain_in = stage;
  assign take     = din_vld && (phase == COLLECT);

  generate
    if (CHAINS == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    stage <= '0;
        else if (take) stage <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)    stage <= '0;
        else if (take) stage <= {din, stage[CHAINS-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= COLLECT;
      bit_cnt <= '0;
      pos_cnt <= '0;
      pat_cnt <= '0;
      err     <= 1'b0;
    end else begin
      if (din_vld && busy) err <= 1'b1;
      case (phase)
        COLLECT: if (take) begin
          if (bit_cnt == BIT_LAST) begin
            bit_cnt <= '0;
            phase   <= XFER;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        XFER: begin
          if (pos_cnt == POS_LAST) begin
            pos_cnt <= '0;
            phase   <= APPLY;
          end else begin
            pos_cnt <= pos_cnt + 1'b1;
            phase   <= COLLECT;
          end
        end
        APPLY: begin
          pat_cnt <= pat_cnt + 1'b1;
          bit_cnt <= '0;
          pos_cnt <= '0;
          phase   <= COLLECT;
        end
        default: phase <= COLLECT;
      endcase
    end
  end
endmodule

// File: rtl/scan_load_ctrl_chk.sv
module scan_load_ctrl_chk #(
  parameter int PAT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             din_vld,
  input logic             busy,
  input logic             scan_en,
  input logic             func_en,
  input logic             err,
  input logic [PAT_W-1:0] pat_cnt
);
  // R3
  scan_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> !scan_en);

  // R3
  scan_func_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(scan_en && func_en));

  // R5
  func_after_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(func_en) |-> $past(scan_en));

  // R6
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (scan_en || func_en));

  // R7
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && busy) |=> err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R8
  pat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_en |=> (pat_cnt == PAT_W'($past(pat_cnt) + 1'b1)));

  // R8
  pat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> $stable(pat_cnt));

  // R9
  func_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    func_en |=> (!busy && !func_en));
endmodule

bind scan_load_ctrl scan_load_ctrl_chk #(.PAT_W(PAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .din_vld(din_vld), .busy(busy),
  .scan_en(scan_en), .func_en(func_en), .err(err), .pat_cnt(pat_cnt)
);

// File: tb/scan_load_ctrl_tb.sv
module scan_load_ctrl_tb;
  localparam int S = 4;
  localparam int L = 3;
  localparam int P = 3;
  localparam int N = S * L;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0;
  logic din_vld = 1'b0;
  logic busy, scan_en, func_en, err;
  logic [S-1:0] chain_in;
  logic [P-1:0] pat_cnt;

  int checks = 0;
  int errors = 0;
  int pats = 0;
  logic [L-1:0] model [S];

  always #4 clk = ~clk;

  scan_load_ctrl #(.CHAINS(S), .CHAIN_LEN(L), .PAT_W(P)) u_dut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .busy(busy),
    .scan_en(scan_en), .func_en(func_en), .chain_in(chain_in),
    .pat_cnt(pat_cnt), .err(err)
  );

  always @(negedge clk)
    if (scan_en)
      for (int c = 0; c < S; c++) model[c] <= {model[c][L-2:0], chain_in[c]};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_pattern(input logic [N-1:0] st, input int gap, input bit poke);
    logic [S-1:0] grp;
    logic [L-1:0] e;
    for (int j = 0; j < L; j++) begin
      for (int c = 0; c < S; c++) begin
        for (int g = 0; g < gap; g++) begin
          din = ~din;
          @(negedge clk);
          chk(!busy && !scan_en, "R2 idle gap", {busy, scan_en}, 0);
        end
        din_vld = 1'b1;
        din = st[j*S+c];
        grp[c] = st[j*S+c];
        @(negedge clk);
        din_vld = 1'b0;
        din = ~din;
        if (c == S-1) begin
          chk(scan_en && busy && !func_en, "R3 transfer pulse", {scan_en, busy, func_en}, 3'b110);
          chk(chain_in == grp, "R4 chain_in group", chain_in, grp);
          if (j < L-1) begin
            if (poke) begin din_vld = 1'b1; din = ~grp[0]; end
            @(negedge clk);
            din_vld = 1'b0;
            chk(!scan_en && !busy && !func_en, "R6 release after transfer", {scan_en, busy, func_en}, 0);
          end
        end else begin
          chk(!busy && !scan_en, "R2 collecting", {busy, scan_en}, 0);
        end
      end
    end
    @(negedge clk);
    chk(func_en && busy && !scan_en, "R5 capture pulse", {func_en, busy, scan_en}, 3'b110);
    for (int c = 0; c < S; c++) begin
      for (int j = 0; j < L; j++) e[L-1-j] = st[j*S+c];
      chk(model[c] == e, "R4 chain contents", model[c], e);
    end
    pats++;
    @(negedge clk);
    chk(!func_en && !busy, "R9 resume collecting", {func_en, busy}, 0);
    chk(pat_cnt == P'(pats), "R8 pattern count", pat_cnt, P'(pats));
  endtask

  task automatic test_reset();
    chk(!busy && !scan_en && !func_en && !err, "R1 reset outputs", {busy, scan_en, func_en, err}, 0);
    chk(pat_cnt == 0, "R1 reset count", pat_cnt, 0);
  endtask

  task automatic test_basic();
    run_pattern({N{1'b1}}, 0, 1'b0);
    run_pattern(12'b1010_0110_0001, 0, 1'b0);
    chk(!err, "R7 no error on clean stream", err, 0);
  endtask

  task automatic test_gaps();
    run_pattern(12'b0111_1000_1101, 2, 1'b0);
    run_pattern(12'b1000_0000_0001, 1, 1'b0);
  endtask

  task automatic test_back_to_back();
    logic [N-1:0] v = 12'h5a3;
    for (int k = 0; k < 3; k++) begin
      v = N'(v * 13 + 7);
      run_pattern(v, 0, 1'b0);
    end
  endtask

  task automatic test_violation();
    run_pattern(12'b0011_0101_1100, 0, 1'b1);
    chk(err, "R7 error flag set", err, 1);
    repeat (3) @(negedge clk);
    chk(err, "R7 error flag sticky", err, 1);
  endtask

  task automatic test_wrap();
    run_pattern(12'b1100_1010_0110, 0, 1'b0);
    chk(pat_cnt == 1, "R8 count wrapped", pat_cnt, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_basic();
    test_gaps();
    test_back_to_back();
    test_violation();
    test_wrap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule